// File: doc/BRIEF.md
# Programmable Logic Output Macrocell

This block is one output cell of a small sum-of-products logic device. A vector of array inputs (dedicated inputs plus feedback from other cells) feeds eight programmable product terms. Four are data terms whose OR forms the cell's logic value. The other four are control terms: a register clock, an asynchronous-style set, an asynchronous-style reset and an output enable. A static fuse map sets which literals each term uses, and a configuration bit sets the output polarity.

The cell holds one D register. The register captures the data sum when the clock term rises. It is forced high by the set term and low by the reset term. A preload path loads it from the pin, and reset clears it. When the set and reset terms are both true, the cell bypasses the register and the pin follows the data sum directly. The enable term, together with an external active-low enable pin, decides whether the cell drives its pin. The feedback output returns either the driven value or the external pin value to the array. All register activity is sampled on one fabric clock.

Top module: `pal_macrocell`

## Requirements
- R1: Each term uses two fuse bits per array input i, inside the term's field of 2*N_IN bits. Bit 2i connects the true literal and bit 2i+1 connects the complement. A term is the AND of its connected literals, so a term with no connected bits is true. A term with both literals of one input connected is false. Terms 0..N_DATA-1 are data terms. They are followed in order by the clock, set, reset and enable terms, and term t sits at fuse bits [t*2*N_IN +: 2*N_IN].
- R2: The cell's logic value is the OR of the data terms.
- R3: While the set and reset terms are both true, pin_out equals the data sum (after polarity) in the same cycle. The register holds its value during this time.
- R4: With neither set nor reset true and preload inactive, the register takes the data sum at the fabric clock edge where the clock term is seen high after being low. A clock term that stays high or falls does not change the register.
- R5: With only the set term true, the register becomes 1 at the next fabric edge, whatever the clock term does.
- R6: With only the reset term true, the register becomes 0 at the next fabric edge, whatever the clock term does.
- R7: pin_out is the cell value XOR pol_inv, so pol_inv=1 gives an active-low pin.
- R8: pin_oe is 1 exactly when the enable term is true and oe_n_pin is 0.
- R9: fb equals pin_out while pin_oe is 1 and pin_in otherwise. This gives current-state feedback in registered mode.
- R10: With preload_n at 0, the register loads pin_in XOR pol_inv at the next fabric edge, so pin_out then reads the impressed pin value. Preload overrides set, reset and the clock term.
- R11: rst clears the register and the clock-edge history, so after reset an active-low pin reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples all register activity |
| rst | input | 1 | Synchronous active-high power-up reset |
| arr_in | input | N_IN | Array inputs (dedicated inputs and feedback) |
| fuse_map | input | (N_DATA+4)*2*N_IN | Static fuse bits for all product terms |
| pol_inv | input | 1 | 1 inverts the cell value at the pin |
| oe_n_pin | input | 1 | External active-low output enable |
| preload_n | input | 1 | Active-low preload request |
| pin_in | input | 1 | Value on the pin when driven from outside |
| pin_out | output | 1 | Value the cell drives onto its pin |
| pin_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Pin value returned to the array |

## Verification
The hardest state to reach from the ports is the switch in and out of the bypass mode, where set and reset are both true. The register has to keep the value it held before the bypass, while the pin shows live sums. The bench gets there with one fuse map that ties the clock, set and reset terms each to a single array input. It drives the register to a known state, raises both control inputs while toggling the data input, and then drops them to confirm that the old state returns. A toggle machine closes feedback through fb into the array, and a near-exhaustive sweep of fuse maps and inputs covers the term logic in bypass mode.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;
  // Control term positions after the data terms (order fixed by fuse layout)
  typedef enum logic [1:0] {
    CT_CLK = 2'd0,
    CT_SET = 2'd1,
    CT_RST = 2'd2,
    CT_OE  = 2'd3
  } ctrl_term_e;

  localparam int unsigned N_CTRL = 4;
  localparam int unsigned FUSES_PER_INPUT = 2;
endpackage

// File: rtl/pal_pterm.sv
module pal_pterm #(
  parameter int unsigned N_IN = 4
) (
  input  logic [N_IN-1:0]   arr,
  input  logic [2*N_IN-1:0] fuse,
  output logic              term
);
  logic [N_IN-1:0] lit_ok;

  // R1: a literal only constrains the AND when its fuse is connected
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit_ok[i] = (~fuse[2*i] | arr[i]) & (~fuse[2*i+1] | ~arr[i]);
  end

  assign term = &lit_ok;
endmodule

// File: rtl/pal_term_array.sv
module pal_term_array
  import pal_mc_pkg::*;
#(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_DATA = 4
) (
  input  logic [N_IN-1:0]                        arr,
  input  logic [(N_DATA+N_CTRL)*2*N_IN-1:0]      fuse_map,
  output logic [N_DATA-1:0]                      data_terms,
  output logic                                   clk_t,
  output logic                                   set_t,
  output logic                                   rst_t,
  output logic                                   oe_t
);
  localparam int unsigned N_TERMS = N_DATA + N_CTRL;
  localparam int unsigned TERM_W  = FUSES_PER_INPUT * N_IN;

  logic [N_TERMS-1:0] terms;

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    pal_pterm #(.N_IN(N_IN)) u_term (
      .arr  (arr),
      .fuse (fuse_map[t*TERM_W +: TERM_W]),
      .term (terms[t])
    );
  end

  assign data_terms = terms[N_DATA-1:0];
  assign clk_t = terms[N_DATA + int'(CT_CLK)];
  assign set_t = terms[N_DATA + int'(CT_SET)];
  assign rst_t = terms[N_DATA + int'(CT_RST)];
  assign oe_t  = terms[N_DATA + int'(CT_OE)];
endmodule

// File: rtl/pal_mc_reg.sv
module pal_mc_reg (
  input  logic clk,
  input  logic rst,
  input  logic clk_term,
  input  logic set_t,
  input  logic rst_t,
  input  logic preload_n,
  input  logic pl_val,
  input  logic d,
  output logic q
);
  logic clk_term_d;
  logic clk_rise;
  logic rst_seen;

  assign clk_rise = clk_term & ~clk_term_d;

  always_ff @(posedge clk) begin
    if (rst) clk_term_d <= 1'b0;
    else     clk_term_d <= clk_term;
  end

  // Priority: reset, preload, bypass hold, set, reset term, clock edge
  always_ff @(posedge clk) begin
    if (rst)                      q <= 1'b0;
    else if (!preload_n)          q <= pl_val;
    else if (set_t && rst_t)      q <= q;
    else if (set_t)               q <= 1'b1;
    else if (rst_t)               q <= 1'b0;
    else if (clk_rise)            q <= d;
  end

  always_ff @(posedge clk) rst_seen <= rst;

  always_comb begin
    if (rst_seen) begin
      p_powerup_low_r11: assert (q == 1'b0) else $error("register not cleared by reset");
    end
  end

  p_set_r5: assert property (@(posedge clk) disable iff (rst)
    (preload_n && set_t && !rst_t) |=> q);

  p_reset_r6: assert property (@(posedge clk) disable iff (rst)
    (preload_n && rst_t && !set_t) |=> !q);

  p_preload_r10: assert property (@(posedge clk) disable iff (rst)
    !preload_n |=> (q == $past(pl_val)));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (preload_n && ((set_t && rst_t) || (!set_t && !rst_t && !clk_rise))) |=> $stable(q));

  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (preload_n && !set_t && !rst_t && clk_rise) |=> (q == $past(d)));
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_mc_pkg::*;
#(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_DATA = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [N_IN-1:0]                        arr_in,
  input  logic [(N_DATA+N_CTRL)*2*N_IN-1:0]      fuse_map,
  input  logic                                   pol_inv,
  input  logic                                   oe_n_pin,
  input  logic                                   preload_n,
  input  logic                                   pin_in,
  output logic                                   pin_out,
  output logic                                   pin_oe,
  output logic                                   fb
);
  logic [N_DATA-1:0] data_terms;
  logic clk_t, set_t, rst_t, oe_t;
  logic sum, q, bypass, cell_val;

  pal_term_array #(.N_IN(N_IN), .N_DATA(N_DATA)) u_array (
    .arr        (arr_in),
    .fuse_map   (fuse_map),
    .data_terms (data_terms),
    .clk_t      (clk_t),
    .set_t      (set_t),
    .rst_t      (rst_t),
    .oe_t       (oe_t)
  );

  assign sum = |data_terms;

  pal_mc_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .clk_term  (clk_t),
    .set_t     (set_t),
    .rst_t     (rst_t),
    .preload_n (preload_n),
    .pl_val    (pin_in ^ pol_inv),
    .d         (sum),
    .q         (q)
  );

  assign bypass   = set_t & rst_t;
  assign cell_val = bypass ? sum : q;
  assign pin_out  = cell_val ^ pol_inv;
  assign pin_oe   = oe_t & ~oe_n_pin;
  assign fb       = pin_oe ? pin_out : pin_in;

  p_ext_enable_r8: assert property (@(posedge clk) disable iff (rst)
    oe_n_pin |-> !pin_oe);

  p_fb_input_r9: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> (fb == pin_in));

  p_fb_output_r9: assert property (@(posedge clk) disable iff (rst)
    pin_oe |-> (fb == pin_out));
endmodule

// File: tb/test_pal_macrocell.sv
module test_pal_macrocell;
  localparam int N_IN = 4;
  localparam int N_DATA = 4;
  localparam int FW = (N_DATA + 4) * 2 * N_IN;
  localparam int T_CLK = N_DATA, T_SET = N_DATA + 1, T_RST = N_DATA + 2, T_OE = N_DATA + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_IN-1:0] arr_in = '0;
  logic [FW-1:0] fuse_map = '0;
  logic pol_inv = 1'b0, oe_n_pin = 1'b0, preload_n = 1'b1, pin_in = 1'b0;
  logic pin_out, pin_oe, fb;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pal_macrocell #(.N_IN(N_IN), .N_DATA(N_DATA)) i_pal_macrocell (
    .clk(clk), .rst(rst), .arr_in(arr_in), .fuse_map(fuse_map),
    .pol_inv(pol_inv), .oe_n_pin(oe_n_pin), .preload_n(preload_n),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (arr=%b)", req, got, exp, arr_in);
    end
  endtask

  // Fuse field for one term: true-literal mask and complement-literal mask
  function automatic logic [2*N_IN-1:0] tf(input logic [N_IN-1:0] tm, input logic [N_IN-1:0] cm);
    logic [2*N_IN-1:0] f;
    for (int i = 0; i < N_IN; i++) begin
      f[2*i]   = tm[i];
      f[2*i+1] = cm[i];
    end
    return f;
  endfunction

  function automatic logic term_of(input logic [FW-1:0] fm, input int t, input logic [N_IN-1:0] a);
    logic [2*N_IN-1:0] f;
    logic ok;
    f = fm[t*2*N_IN +: 2*N_IN];
    ok = 1'b1;
    for (int i = 0; i < N_IN; i++)
      if ((f[2*i] && !a[i]) || (f[2*i+1] && a[i])) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic sum_of(input logic [FW-1:0] fm, input logic [N_IN-1:0] a);
    logic s;
    s = 1'b0;
    for (int t = 0; t < N_DATA; t++) s = s | term_of(fm, t, a);
    return s;
  endfunction

  task automatic apply(input logic [N_IN-1:0] a);
    @(negedge clk);
    arr_in = a;
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  localparam logic [2*N_IN-1:0] NEVER = 8'b0000_0011; // both literals of input 0

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [FW-1:0] fm_reg;
    logic [FW-1:0] cfgs [4];
    logic [N_IN-1:0] s;
    // Registered config: data t0 = in0, clock = in3, set = in2, reset = in1, enable always
    fm_reg = '0;
    fm_reg[0*8 +: 8] = tf(4'b0001, 4'b0000);
    fm_reg[1*8 +: 8] = NEVER;
    fm_reg[2*8 +: 8] = NEVER;
    fm_reg[3*8 +: 8] = NEVER;
    fm_reg[T_CLK*8 +: 8] = tf(4'b1000, 4'b0000);
    fm_reg[T_SET*8 +: 8] = tf(4'b0100, 4'b0000);
    fm_reg[T_RST*8 +: 8] = tf(4'b0010, 4'b0000);

    // R11: reset clears the register, active-low pin reads high
    fuse_map = fm_reg;
    pol_inv = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 active-low after reset", pin_out, 1'b1);
    pol_inv = 1'b0;
    #1;
    chk("R11 register low after reset", pin_out, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R4: capture on rising clock term only
    apply(4'b0001); settle(); chk("R4 no capture without rise", pin_out, 1'b0);
    apply(4'b1001); settle(); chk("R4 capture on rise", pin_out, 1'b1);
    apply(4'b1000); settle(); chk("R4 held high no capture", pin_out, 1'b1);
    apply(4'b0000); settle(); chk("R4 falling no capture", pin_out, 1'b1);
    apply(4'b1000); settle(); chk("R4 capture zero on rise", pin_out, 1'b0);
    apply(4'b0000);
    // R5 / R6: set and reset terms
    apply(4'b0100); settle(); chk("R5 set term", pin_out, 1'b1);
    apply(4'b0000); settle(); chk("R5 set holds after release", pin_out, 1'b1);
    apply(4'b0010); settle(); chk("R6 reset term", pin_out, 1'b0);
    apply(4'b1010); settle(); chk("R6 reset beats clock rise", pin_out, 1'b0);
    apply(4'b0000);
    apply(4'b1100); settle(); chk("R5 set beats clock rise with data 0", pin_out, 1'b1);
    apply(4'b0000);
    // R3: bypass mode follows sum immediately, register keeps its value
    apply(4'b0110); chk("R3 bypass sum 0", pin_out, 1'b0);
    apply(4'b0111); chk("R3 bypass sum 1", pin_out, 1'b1);
    apply(4'b0110); chk("R3 bypass back to 0", pin_out, 1'b0);
    settle();
    apply(4'b0000); chk("R3 register kept through bypass", pin_out, 1'b1);
    pol_inv = 1'b1; #1;
    chk("R7 polarity inverts registered value", pin_out, 1'b0);
    pol_inv = 1'b0;

    // R10: preload from pin, overriding set
    @(negedge clk); preload_n = 1'b0; pin_in = 1'b0; arr_in = 4'b0100;
    settle(); chk("R10 preload beats set", pin_out, 1'b0);
    @(negedge clk); preload_n = 1'b1; arr_in = 4'b0000;
    settle(); chk("R10 preload value kept", pin_out, 1'b0);
    @(negedge clk); pol_inv = 1'b1; preload_n = 1'b0; pin_in = 1'b1;
    settle(); chk("R10 preload active-low pin reads 1", pin_out, 1'b1);
    @(negedge clk); pin_in = 1'b0;
    settle(); chk("R10 preload active-low pin reads 0", pin_out, 1'b0);
    @(negedge clk); preload_n = 1'b1; pol_inv = 1'b0; pin_in = 1'b0;

    // R9: toggle machine, data = ~in0 with in0 driven from fb
    fuse_map[0*8 +: 8] = tf(4'b0000, 4'b0001);
    apply(4'b0010); settle(); // clear
    for (int k = 0; k < 4; k++) begin
      apply({3'b000, fb});
      apply({3'b100, fb});
      settle();
      chk("R9 feedback toggle", pin_out, logic'((k % 2) == 0));
    end

    // R1 / R2 / R7: sweep of fuse maps in bypass mode (set/reset terms unconnected)
    for (int c = 0; c < 4; c++) cfgs[c] = '0;
    cfgs[0][0*8 +: 8] = tf(4'b0011, 4'b0000);
    cfgs[0][1*8 +: 8] = tf(4'b0000, 4'b0100);
    cfgs[0][2*8 +: 8] = NEVER; cfgs[0][3*8 +: 8] = NEVER;
    cfgs[1][1*8 +: 8] = NEVER; cfgs[1][2*8 +: 8] = NEVER; cfgs[1][3*8 +: 8] = NEVER;
    cfgs[2][0*8 +: 8] = NEVER; cfgs[2][1*8 +: 8] = tf(4'b0100, 4'b0100);
    cfgs[2][2*8 +: 8] = tf(4'b1000, 4'b1000); cfgs[2][3*8 +: 8] = NEVER;
    cfgs[3][0*8 +: 8] = tf(4'b0001, 4'b1000);
    cfgs[3][1*8 +: 8] = tf(4'b0110, 4'b0000);
    cfgs[3][2*8 +: 8] = tf(4'b0000, 4'b0011);
    cfgs[3][3*8 +: 8] = tf(4'b1000, 4'b0010);
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 2; p++) begin
        for (int a = 0; a < 16; a++) begin
          @(negedge clk);
          fuse_map = cfgs[c]; pol_inv = p[0]; arr_in = a[3:0];
          #1;
          s = a[3:0];
          chk("R1 R2 R7 term sum at pin", pin_out, sum_of(cfgs[c], s) ^ p[0]);
        end
      end
    end

    // R8 / R9: enable term = in2, external enable, pin feedback selection
    fuse_map = cfgs[3];
    fuse_map[T_OE*8 +: 8] = tf(4'b0100, 4'b0000);
    pol_inv = 1'b0;
    for (int a = 0; a < 16; a++) begin
      for (int e = 0; e < 2; e++) begin
        for (int pi = 0; pi < 2; pi++) begin
          @(negedge clk);
          arr_in = a[3:0]; oe_n_pin = e[0]; pin_in = pi[0];
          #1;
          s = a[3:0];
          chk("R8 output enable", pin_oe, s[2] & ~e[0]);
          chk("R9 feedback source", fb, (s[2] & ~e[0]) ? sum_of(cfgs[3], s) : pi[0]);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule